// File: doc/BRIEF.md
# Nested Trap Level State Stack

This block keeps the processor state that a trap must be able to restore, and it keeps one copy for each nesting level. When a trap is requested, the block records three things for the current level. The first is a packed state word holding the condition codes, the address-space identifier, the 12-bit status word and the register window pointer. The second is the current PC and next-PC. The third is the incoming trap type. The block then raises the level, forces the status word to a privileged entry value and sends execution to a vector built from the trap base register and the trap type. The vector also records whether the trap arrived while the processor was already inside a trap.

Two return requests unwind one level. The resume-after flavour continues at the saved next-PC. The re-execute flavour goes back to the saved PC. Both reload the condition codes, address-space identifier, status word and window pointer from the saved state word. As the level approaches the maximum, the block sets a reduced-state bit in the status word. A trap that arrives at the maximum level, or a return at level zero, changes nothing and only raises a one-cycle error pulse. The outputs are registered and hold the new architectural state, and the surrounding pipeline loads them when the update pulse is high.

Top module: `trap_level_stack`

## Requirements
- R1: After reset the level is 0, every state output is 0, the saved trap type output is 0, and the update and error pulses are low.
- R2: A trap taken at level L stores at slot L a state word with condition codes in bits [39:32], address-space identifier in bits [31:24], zero in bits [23:20], status word in bits [19:8] and window pointer in bits [7:0]. The same slot also stores the PC, next-PC and trap type. A later return from level L+1 gives these values back.
- R3: On a taken trap the status word output becomes 12'h015, with bit 4 for floating point enable, bit 2 for privileged and bit 0 for alternate globals. When the level before the trap is MAXTL-1 or higher, bit 5 (reduced state) is also set, giving 12'h035.
- R4: On a taken trap the vector equals the trap base with bits [14:0] replaced. Bit 14 is 1 when the level before the trap is greater than 1, bits [13:5] hold the 9-bit trap type, and bits [4:0] are 0. The PC output and the trap base output equal the vector, and the next-PC output equals the vector plus 4. Condition codes, address-space identifier and window pointer pass through from the current inputs.
- R5: A trap taken below MAXTL increments the level by one.
- R6: A trap requested at level MAXTL raises the error pulse and leaves the level, the stack and all state outputs unchanged.
- R7: The resume-after return decrements the level, sets the PC output to the saved next-PC and sets the next-PC output to the saved next-PC plus 4.
- R8: The re-execute return decrements the level, sets the PC output to the saved PC and sets the next-PC output to the saved next-PC.
- R9: Both returns restore condition codes, address-space identifier, status word and window pointer from the saved state word, and the trap base output takes the current trap base input.
- R10: A return requested at level 0 raises the error pulse and changes nothing else.
- R11: When requests coincide, a trap wins over both returns, and resume-after wins over re-execute.
- R12: The update pulse is high for exactly the one cycle after an accepted request. The update and error pulses are never high together. Without an accepted request the state outputs hold their values.
- R13: The saved trap type output shows the trap type stored at slot level-1, or 0 at level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Trap entry strobe |
| done_req | input | 1 | Resume-after return strobe |
| retry_req | input | 1 | Re-execute return strobe |
| trap_type | input | 9 | Trap type of the entry request |
| cur_pc | input | 64 | Current PC |
| cur_npc | input | 64 | Current next-PC |
| cur_ccr | input | 8 | Current condition codes |
| cur_asi | input | 8 | Current address-space identifier |
| cur_status | input | 12 | Current status word |
| cur_wp | input | 8 | Current window pointer |
| cur_tbase | input | 64 | Current trap base register |
| level_o | output | 3 | Current trap level |
| nxt_pc | output | 64 | New PC |
| nxt_npc | output | 64 | New next-PC |
| nxt_ccr | output | 8 | New condition codes |
| nxt_asi | output | 8 | New address-space identifier |
| nxt_status | output | 12 | New status word |
| nxt_wp | output | 8 | New window pointer |
| nxt_tbase | output | 64 | New trap base |
| top_tt | output | 9 | Trap type saved at the top occupied slot |
| upd_o | output | 1 | New state valid, one cycle |
| err_o | output | 1 | Rejected request, one cycle |

## Verification
A wrong level count shows up on level_o one cycle after the request. It also shows up on the vector nesting bit of the next trap, on the reduced-state bit, and on which slot a later return reads. A corrupted or misindexed stack slot stays hidden until the matching return unwinds to it. That return then produces wrong PC, next-PC or restored fields one cycle after its strobe, and top_tt already shows the mismatch as soon as that slot becomes the top. Random mixes of traps, both returns, coincident strobes and idle cycles run up to the maximum level and back down, so faults that stay hidden for several levels are still brought out at the ports.

// File: rtl/tls_pkg.sv
package tls_pkg;
    localparam int ADDR_W    = 64;
    localparam int CCR_W     = 8;
    localparam int ASI_W     = 8;
    localparam int STAT_W    = 12;
    localparam int WP_W      = 8;
    localparam int TT_W      = 9;
    localparam int PAD_W     = 4;
    localparam int SW_W      = CCR_W + ASI_W + PAD_W + STAT_W + WP_W;

    // status word bit positions
    localparam int ST_ALTG    = 0;
    localparam int ST_PRIV    = 2;
    localparam int ST_FPEN    = 4;
    localparam int ST_REDUCED = 5;

    // vector layout
    localparam int VEC_LOW_W    = 15;
    localparam int VEC_NEST_BIT = 14;
    localparam int VEC_TT_LSB   = 5;

    typedef struct packed {
        logic [SW_W-1:0]   sw;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] npc;
        logic [TT_W-1:0]   tt;
    } frame_t;

    function automatic logic [SW_W-1:0] pack_sw(
        input logic [CCR_W-1:0]  ccr,
        input logic [ASI_W-1:0]  asi,
        input logic [STAT_W-1:0] st,
        input logic [WP_W-1:0]   wp
    );
        return {ccr, asi, {PAD_W{1'b0}}, st, wp};
    endfunction
endpackage

// File: rtl/tls_entry_calc.sv
module tls_entry_calc
    import tls_pkg::*;
#(
    parameter int MAXTL = 5,
    parameter int LVL_W = 3
) (
    input  logic [LVL_W-1:0]  lvl,
    input  logic [TT_W-1:0]   tt,
    input  logic [ADDR_W-1:0] tbase,
    output logic [ADDR_W-1:0] vector,
    output logic [STAT_W-1:0] entry_status,
    output logic [LVL_W-1:0]  lvl_next,
    output logic              at_max
);
    logic              nested;
    logic              reduced;
    logic [VEC_LOW_W-1:0] unused_tbase_low;

    assign unused_tbase_low = tbase[VEC_LOW_W-1:0];

    always_comb begin
        nested  = int'(lvl) > 1;
        reduced = int'(lvl) >= MAXTL - 1;
        at_max  = int'(lvl) == MAXTL;
        vector  = {tbase[ADDR_W-1:VEC_LOW_W], nested, tt, {VEC_TT_LSB{1'b0}}};
        entry_status = '0;
        entry_status[ST_FPEN]    = 1'b1;
        entry_status[ST_PRIV]    = 1'b1;
        entry_status[ST_ALTG]    = 1'b1;
        entry_status[ST_REDUCED] = reduced;
        lvl_next = at_max ? lvl : lvl + LVL_W'(1);
    end
endmodule

// File: rtl/tls_frame_store.sv
module tls_frame_store
    import tls_pkg::*;
#(
    parameter int DEPTH = 5,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  frame_t           wr_frame,
    input  logic [IDX_W-1:0] rd_idx,
    output frame_t           rd_frame
);
    frame_t slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en && int'(wr_idx) == g) begin
                slot_q[g] <= wr_frame;
            end
        end
    end

    always_comb begin
        rd_frame = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (int'(rd_idx) == i) begin
                rd_frame = slot_q[i];
            end
        end
    end
endmodule

// File: rtl/trap_level_stack.sv
module trap_level_stack
    import tls_pkg::*;
#(
    parameter int MAXTL = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_req,
    input  logic              done_req,
    input  logic              retry_req,
    input  logic [TT_W-1:0]   trap_type,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [ADDR_W-1:0] cur_npc,
    input  logic [CCR_W-1:0]  cur_ccr,
    input  logic [ASI_W-1:0]  cur_asi,
    input  logic [STAT_W-1:0] cur_status,
    input  logic [WP_W-1:0]   cur_wp,
    input  logic [ADDR_W-1:0] cur_tbase,
    output logic [2:0]        level_o,
    output logic [ADDR_W-1:0] nxt_pc,
    output logic [ADDR_W-1:0] nxt_npc,
    output logic [CCR_W-1:0]  nxt_ccr,
    output logic [ASI_W-1:0]  nxt_asi,
    output logic [STAT_W-1:0] nxt_status,
    output logic [WP_W-1:0]   nxt_wp,
    output logic [ADDR_W-1:0] nxt_tbase,
    output logic [TT_W-1:0]   top_tt,
    output logic              upd_o,
    output logic              err_o
);
    localparam int LVL_W = $clog2(MAXTL + 1);

    typedef struct packed {
        logic [LVL_W-1:0]  level;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] npc;
        logic [ADDR_W-1:0] tbase;
        logic [CCR_W-1:0]  ccr;
        logic [ASI_W-1:0]  asi;
        logic [STAT_W-1:0] status;
        logic [WP_W-1:0]   wp;
        logic              upd;
        logic              err;
    } state_t;

    state_t st_d, st_q;

    logic [ADDR_W-1:0] vector;
    logic [STAT_W-1:0] entry_status;
    logic [LVL_W-1:0]  lvl_next;
    logic              at_max;
    logic              push_en;
    frame_t            push_frame;
    frame_t            top_frame;
    logic [LVL_W-1:0]  top_idx;
    logic [PAD_W-1:0]  unused_pad;

    assign top_idx    = st_q.level - LVL_W'(1);
    assign unused_pad = top_frame.sw[WP_W+STAT_W +: PAD_W];

    tls_entry_calc #(.MAXTL(MAXTL), .LVL_W(LVL_W)) u_entry (
        .lvl          (st_q.level),
        .tt           (trap_type),
        .tbase        (cur_tbase),
        .vector       (vector),
        .entry_status (entry_status),
        .lvl_next     (lvl_next),
        .at_max       (at_max)
    );

    tls_frame_store #(.DEPTH(MAXTL), .IDX_W(LVL_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (push_en),
        .wr_idx   (st_q.level),
        .wr_frame (push_frame),
        .rd_idx   (top_idx),
        .rd_frame (top_frame)
    );

    always_comb begin
        st_d       = st_q;
        st_d.upd   = 1'b0;
        st_d.err   = 1'b0;
        push_en    = 1'b0;
        push_frame.sw  = pack_sw(cur_ccr, cur_asi, cur_status, cur_wp);
        push_frame.pc  = cur_pc;
        push_frame.npc = cur_npc;
        push_frame.tt  = trap_type;

        if (trap_req) begin
            if (at_max) begin
                st_d.err = 1'b1;
            end else begin
                push_en     = 1'b1;
                st_d.level  = lvl_next;
                st_d.pc     = vector;
                st_d.npc    = vector + ADDR_W'(4);
                st_d.tbase  = vector;
                st_d.status = entry_status;
                st_d.ccr    = cur_ccr;
                st_d.asi    = cur_asi;
                st_d.wp     = cur_wp;
                st_d.upd    = 1'b1;
            end
        end else if (done_req || retry_req) begin
            if (st_q.level == '0) begin
                st_d.err = 1'b1;
            end else begin
                st_d.level  = top_idx;
                st_d.pc     = done_req ? top_frame.npc : top_frame.pc;
                st_d.npc    = done_req ? top_frame.npc + ADDR_W'(4) : top_frame.npc;
                st_d.ccr    = top_frame.sw[SW_W-1 -: CCR_W];
                st_d.asi    = top_frame.sw[SW_W-CCR_W-1 -: ASI_W];
                st_d.status = top_frame.sw[WP_W +: STAT_W];
                st_d.wp     = top_frame.sw[WP_W-1:0];
                st_d.tbase  = cur_tbase;
                st_d.upd    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o    = 3'(st_q.level);
    assign nxt_pc     = st_q.pc;
    assign nxt_npc    = st_q.npc;
    assign nxt_ccr    = st_q.ccr;
    assign nxt_asi    = st_q.asi;
    assign nxt_status = st_q.status;
    assign nxt_wp     = st_q.wp;
    assign nxt_tbase  = st_q.tbase;
    assign upd_o      = st_q.upd;
    assign err_o      = st_q.err;
    assign top_tt     = (st_q.level == '0) ? '0 : top_frame.tt;
endmodule

// File: rtl/tls_checker.sv
module tls_checker
    import tls_pkg::*;
#(
    parameter int MAXTL = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trap_req,
    input logic              done_req,
    input logic              retry_req,
    input logic [2:0]        level_o,
    input logic [ADDR_W-1:0] nxt_pc,
    input logic [ADDR_W-1:0] nxt_npc,
    input logic [STAT_W-1:0] nxt_status,
    input logic              upd_o,
    input logic              err_o
);
    logic ret_any;
    assign ret_any = !trap_req && (done_req || retry_req);

    AST_TRAP_RAISES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && int'(level_o) < MAXTL) |=> (level_o == $past(level_o) + 3'd1)); // R5

    AST_TRAP_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && int'(level_o) == MAXTL) |=> (err_o && !upd_o && $stable(level_o))); // R6

    AST_ENTRY_NPC: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && int'(level_o) < MAXTL) |=> (nxt_npc == nxt_pc + 64'd4)); // R4

    AST_ENTRY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && int'(level_o) < MAXTL) |=>
            (nxt_status[ST_FPEN] && nxt_status[ST_PRIV] && nxt_status[ST_ALTG])); // R3

    AST_RETURN_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_any && level_o != 3'd0) |=> (level_o == $past(level_o) - 3'd1)); // R7

    AST_EMPTY_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_any && level_o == 3'd0) |=> (err_o && !upd_o && level_o == 3'd0)); // R10

    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_o && err_o)); // R12
endmodule

bind trap_level_stack tls_checker #(.MAXTL(MAXTL)) u_tls_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_req   (trap_req),
    .done_req   (done_req),
    .retry_req  (retry_req),
    .level_o    (level_o),
    .nxt_pc     (nxt_pc),
    .nxt_npc    (nxt_npc),
    .nxt_status (nxt_status),
    .upd_o      (upd_o),
    .err_o      (err_o)
);

// File: tb/tb_trap_level_stack.sv
module tb_trap_level_stack;
    localparam int MAXTL = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 1'b0, done_req = 1'b0, retry_req = 1'b0;
    logic [8:0]  trap_type = '0;
    logic [63:0] cur_pc = '0, cur_npc = '0, cur_tbase = '0;
    logic [7:0]  cur_ccr = '0, cur_asi = '0, cur_wp = '0;
    logic [11:0] cur_status = '0;
    logic [2:0]  level_o;
    logic [63:0] nxt_pc, nxt_npc, nxt_tbase;
    logic [7:0]  nxt_ccr, nxt_asi, nxt_wp;
    logic [11:0] nxt_status;
    logic [8:0]  top_tt;
    logic        upd_o, err_o;

    always #4 clk = ~clk;

    trap_level_stack #(.MAXTL(MAXTL)) dut (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .done_req(done_req),
        .retry_req(retry_req), .trap_type(trap_type), .cur_pc(cur_pc),
        .cur_npc(cur_npc), .cur_ccr(cur_ccr), .cur_asi(cur_asi),
        .cur_status(cur_status), .cur_wp(cur_wp), .cur_tbase(cur_tbase),
        .level_o(level_o), .nxt_pc(nxt_pc), .nxt_npc(nxt_npc),
        .nxt_ccr(nxt_ccr), .nxt_asi(nxt_asi), .nxt_status(nxt_status),
        .nxt_wp(nxt_wp), .nxt_tbase(nxt_tbase), .top_tt(top_tt),
        .upd_o(upd_o), .err_o(err_o)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference model
    int          m_lvl = 0;
    logic [39:0] m_sw  [MAXTL];
    logic [63:0] m_pc  [MAXTL];
    logic [63:0] m_npc [MAXTL];
    logic [8:0]  m_tt  [MAXTL];
    logic [63:0] e_pc = '0, e_npc = '0, e_tb = '0;
    logic [7:0]  e_ccr = '0, e_asi = '0, e_wp = '0;
    logic [11:0] e_st = '0;
    logic        e_upd = 0, e_err = 0;

    function automatic logic [63:0] f_vector(logic [63:0] tb, logic [8:0] tt, int lvl);
        logic [63:0] v;
        v = tb & ~64'h7fff;
        if (lvl > 1) v = v | 64'h4000;
        v = v | (64'(tt) << 5);
        return v;
    endfunction

    function automatic logic [11:0] f_entry_status(int lvl);
        return (lvl >= MAXTL - 1) ? 12'h035 : 12'h015;
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, "level",  64'(level_o), 64'(m_lvl));
        chk(tag, "pc",     nxt_pc, e_pc);
        chk(tag, "npc",    nxt_npc, e_npc);
        chk(tag, "tbase",  nxt_tbase, e_tb);
        chk(tag, "ccr",    64'(nxt_ccr), 64'(e_ccr));
        chk(tag, "asi",    64'(nxt_asi), 64'(e_asi));
        chk(tag, "status", 64'(nxt_status), 64'(e_st));
        chk(tag, "wp",     64'(nxt_wp), 64'(e_wp));
        chk("R12", "upd",  64'(upd_o), 64'(e_upd));
        chk(tag, "err",    64'(err_o), 64'(e_err));
        chk("R13", "top_tt", 64'(top_tt), (m_lvl == 0) ? 64'd0 : 64'(m_tt[m_lvl-1]));
    endtask

    // called at a negedge; checks at the following negedge
    task automatic op(bit tr, bit dn, bit rt, string tag);
        logic [39:0] sw;
        logic [63:0] vec;
        cur_pc     = {$urandom, $urandom};
        cur_npc    = {$urandom, $urandom};
        cur_tbase  = {$urandom, $urandom};
        cur_ccr    = 8'($urandom);
        cur_asi    = 8'($urandom);
        cur_wp     = 8'($urandom);
        cur_status = 12'($urandom);
        trap_type  = 9'($urandom);
        trap_req = tr; done_req = dn; retry_req = rt;
        e_upd = 0; e_err = 0;
        if (tr) begin
            if (m_lvl == MAXTL) begin
                e_err = 1;
            end else begin
                m_sw[m_lvl]  = {cur_ccr, cur_asi, 4'h0, cur_status, cur_wp};
                m_pc[m_lvl]  = cur_pc;
                m_npc[m_lvl] = cur_npc;
                m_tt[m_lvl]  = trap_type;
                vec   = f_vector(cur_tbase, trap_type, m_lvl);
                e_pc  = vec; e_npc = vec + 64'd4; e_tb = vec;
                e_st  = f_entry_status(m_lvl);
                e_ccr = cur_ccr; e_asi = cur_asi; e_wp = cur_wp;
                m_lvl++;
                e_upd = 1;
            end
        end else if (dn || rt) begin
            if (m_lvl == 0) begin
                e_err = 1;
            end else begin
                m_lvl--;
                sw    = m_sw[m_lvl];
                e_pc  = dn ? m_npc[m_lvl] : m_pc[m_lvl];
                e_npc = dn ? m_npc[m_lvl] + 64'd4 : m_npc[m_lvl];
                e_ccr = sw[39:32]; e_asi = sw[31:24];
                e_st  = sw[19:8];  e_wp  = sw[7:0];
                e_tb  = cur_tbase;
                e_upd = 1;
            end
        end
        @(negedge clk);
        trap_req = 0; done_req = 0; retry_req = 0;
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7001));
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1;
        @(negedge clk);
        check_all("R1");

        // empty returns
        op(0, 1, 0, "R10 done at level 0");
        op(0, 0, 1, "R10 retry at level 0");

        // climb to the maximum and past it
        for (int i = 0; i < MAXTL; i++) op(1, 0, 0, "R2 R3 R4 R5 climb");
        op(1, 0, 0, "R6 trap at max");
        op(0, 0, 0, "R12 idle hold");

        // unwind with both flavours
        op(0, 0, 1, "R2 R8 R9 retry");
        op(0, 1, 0, "R2 R7 R9 done");

        // priority
        op(1, 1, 1, "R11 trap wins");
        op(0, 1, 1, "R11 done wins");

        // random mix
        for (int n = 0; n < 600; n++) begin
            int r;
            r = int'($urandom % 16);
            if (r < 7)       op(1, 0, 0, "R3 R4 R5 R6 trap");
            else if (r < 10) op(0, 1, 0, "R2 R7 R9 R10 done");
            else if (r < 13) op(0, 0, 1, "R2 R8 R9 R10 retry");
            else if (r == 13) op(0, 0, 0, "R12 idle");
            else if (r == 14) op(1, 1, 0, "R11 trap over done");
            else              op(0, 1, 1, "R11 done over retry");
        end

        // drain back to zero
        while (m_lvl > 0) op(0, 1, 0, "R7 drain");
        op(0, 0, 1, "R10 final empty");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule